// File: doc/BRIEF.md
# Configurable ECAM Window Decoder

This block keeps a 64-bit window register that places a memory-mapped configuration window somewhere in a 39-bit physical address space. The window can be 256 MB, 128 MB or 64 MB. Each memory read or write request is compared against the programmed base over the range of upper address bits that the selected size defines. A request that falls inside an enabled window is claimed. The block then splits its address into bus, device, function and register offset, so that the request can be reissued as a configuration read or write.

Software programs the window through a plain register write port and reads it back on a continuous read bus. An external lock input freezes the whole register once platform setup is finished. The size field also decides which of the two lowest base bits are storable. A bit that the current size does not use acts as a mask bit and always reads as zero.

Top module: `ecam_window_decoder`

## Requirements
- R1: After a synchronous reset the register reads 0, so the window is disabled and sized 256 MB, and `out_valid` and `out_hit` are 0.
- R2: The size code sits in register bits 2:1. Code 00 selects 256 MB and compares address bits 38:28 with register bits 38:28. Code 01 selects 128 MB and compares bits 38:27. Code 10 selects 64 MB and compares bits 38:26. Register bit 0 is the enable.
- R3: Register bit 27 keeps the written value only when the size code in that same write is 01 or 10. Otherwise it stores and reads 0.
- R4: Register bit 26 keeps the written value only when the size code in that same write is 10. Otherwise it stores and reads 0.
- R5: Register bits 25:3 and 63:39 always read 0, whatever was written.
- R6: While bit 0 is 0, no request is claimed. Base and size bits can still be written and read back.
- R7: While the size code is 11, no request is claimed, even when bit 0 is 1. Bits 27 and 26 read 0.
- R8: While `cfg_lock` is 1, register writes are ignored. The read-back value and the decode stay as they were.
- R9: `out_valid` is `req_valid` delayed by one clock. `out_hit` is 1 only in the cycle after a claimed request.
- R10: On a hit, the outputs are registered one cycle after the request. `out_bus` is address bits 27:20, limited to 8, 7 or 6 bits for 256, 128 or 64 MB. `out_dev` is bits 19:15, `out_fn` is bits 14:12, `out_off` is bits 11:0, and `out_write` equals `req_write`. On a miss, all of these outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 64 | Register write value |
| cfg_lock | input | 1 | Freezes the register when high |
| cfg_rd_data | output | 64 | Current register value, with reserved and mask bits as 0 |
| req_valid | input | 1 | A memory request is present this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 39 | Request address |
| out_valid | output | 1 | Decode result for the previous cycle's request |
| out_hit | output | 1 | The previous request was claimed |
| out_write | output | 1 | The claimed request was a write |
| out_bus | output | 8 | Decoded bus number |
| out_dev | output | 5 | Decoded device number |
| out_fn | output | 3 | Decoded function number |
| out_off | output | 12 | Decoded register offset |

## Verification
The assertions assume that reset is held from time zero until the first clock edges. They also assume that `cfg_wr_en`, `cfg_lock`, `req_valid`, `req_write` and `req_addr` are settled well before each rising edge. The bench meets both assumptions by asserting reset from the start and by changing every input one nanosecond after a rising edge.

Write data and request addresses can take any value, including the reserved size code. The random phase therefore deliberately exercises reserved sizes, lock toggling and addresses that differ from the base in bits 28 to 26.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 39;
  localparam int BASE_HI  = 38;
  localparam int BASE_LO  = 26;
  localparam int BASE_W   = BASE_HI - BASE_LO + 1;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int OFF_W    = 12;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [OFF_W-1:0] off;
  } cfg_fields_t;
endpackage

// File: rtl/ecam_base_reg.sv
module ecam_base_reg
  import ecam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              lock,
  output logic [REG_W-1:0]  rd_data,
  output logic              win_en,
  output win_len_e          win_len,
  output logic [BASE_W-1:0] win_base
);
  logic [1:0] new_len;
  logic       keep27;
  logic       keep26;

  assign new_len = wr_data[2:1];
  assign keep27  = (new_len == LEN_128M) || (new_len == LEN_64M);
  assign keep26  = (new_len == LEN_64M);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en   <= 1'b0;
      win_len  <= LEN_256M;
      win_base <= '0;
    end else if (wr_en && !lock) begin
      win_en                 <= wr_data[0];
      win_len                <= win_len_e'(new_len);
      win_base[BASE_W-1:2]   <= wr_data[BASE_HI:BASE_LO+2];
      win_base[1]            <= wr_data[BASE_LO+1] & keep27;
      win_base[0]            <= wr_data[BASE_LO] & keep26;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[0]               = win_en;
    rd_data[2:1]             = win_len;
    rd_data[BASE_HI:BASE_LO] = win_base;
  end

  // R8: a locked write leaves the register untouched
  a_r8_lock_freezes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock) |=> $stable(rd_data));
  // R3: bit 27 may be set only for the 128 MB or 64 MB size
  a_r3_bit27_size: assert property (@(posedge clk) disable iff (rst)
    rd_data[27] |-> (rd_data[2:1] == 2'b01 || rd_data[2:1] == 2'b10));
  // R4: bit 26 may be set only for the 64 MB size
  a_r4_bit26_size: assert property (@(posedge clk) disable iff (rst)
    rd_data[26] |-> (rd_data[2:1] == 2'b10));
endmodule

// File: rtl/ecam_addr_match.sv
module ecam_addr_match
  import ecam_pkg::*;
(
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_en,
  input  win_len_e          win_len,
  input  logic [BASE_W-1:0] win_base,
  output logic              hit
);
  logic upper_eq;
  logic b27_ok;
  logic b26_ok;

  assign upper_eq = (addr[BASE_HI:BASE_LO+2] == win_base[BASE_W-1:2]);
  assign b27_ok   = (win_len == LEN_256M) || (addr[BASE_LO+1] == win_base[1]);
  assign b26_ok   = (win_len != LEN_64M)  || (addr[BASE_LO] == win_base[0]);
  assign hit      = valid && win_en && (win_len != LEN_RSVD) &&
                    upper_eq && b27_ok && b26_ok;
endmodule

// File: rtl/ecam_field_split.sv
module ecam_field_split
  import ecam_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  win_len_e          win_len,
  output cfg_fields_t       fields
);
  localparam int OFF_LO = 0;
  localparam int FN_LO  = OFF_LO + OFF_W;
  localparam int DEV_LO = FN_LO + FN_W;
  localparam int BUS_LO = DEV_LO + DEV_W;

  always_comb begin
    fields.off = addr[FN_LO-1:OFF_LO];
    fields.fn  = addr[DEV_LO-1:FN_LO];
    fields.dev = addr[BUS_LO-1:DEV_LO];
    unique case (win_len)
      LEN_256M: fields.bus = addr[BUS_LO+BUS_W-1:BUS_LO];
      LEN_128M: fields.bus = {1'b0, addr[BUS_LO+BUS_W-2:BUS_LO]};
      default:  fields.bus = {2'b00, addr[BUS_LO+BUS_W-3:BUS_LO]};
    endcase
  end
endmodule

// File: rtl/ecam_window_decoder.sv
module ecam_window_decoder
  import ecam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              cfg_lock,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_write,
  output logic [BUS_W-1:0]  out_bus,
  output logic [DEV_W-1:0]  out_dev,
  output logic [FN_W-1:0]   out_fn,
  output logic [OFF_W-1:0]  out_off
);
  logic              win_en;
  win_len_e          win_len;
  logic [BASE_W-1:0] win_base;
  logic              hit_c;
  cfg_fields_t       fld_c;
  cfg_fields_t       fld_q;

  ecam_base_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .lock     (cfg_lock),
    .rd_data  (cfg_rd_data),
    .win_en   (win_en),
    .win_len  (win_len),
    .win_base (win_base)
  );

  ecam_addr_match u_match (
    .valid    (req_valid),
    .addr     (req_addr),
    .win_en   (win_en),
    .win_len  (win_len),
    .win_base (win_base),
    .hit      (hit_c)
  );

  ecam_field_split u_split (
    .addr    (req_addr),
    .win_len (win_len),
    .fields  (fld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_write <= 1'b0;
      fld_q     <= '0;
    end else begin
      out_valid <= req_valid;
      out_hit   <= hit_c;
      out_write <= hit_c & req_write;
      fld_q     <= hit_c ? fld_c : '0;
    end
  end

  assign out_bus = fld_q.bus;
  assign out_dev = fld_q.dev;
  assign out_fn  = fld_q.fn;
  assign out_off = fld_q.off;

  // R9: the valid output follows the request strobe by one clock
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  // R9: a hit only ever comes with a valid result
  a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid);
  // R6: a disabled window claims nothing
  a_r6_disabled_no_hit: assert property (@(posedge clk) disable iff (rst)
    !win_en |=> !out_hit);
  // R7: the reserved size claims nothing
  a_r7_reserved_no_hit: assert property (@(posedge clk) disable iff (rst)
    (win_len == LEN_RSVD) |=> !out_hit);
  // R10: a miss leaves every decoded field at zero
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> (!out_write && out_bus == '0 && out_dev == '0 &&
                  out_fn == '0 && out_off == '0));
  // R10: on a hit the direction follows the request
  a_r10_write_dir: assert property (@(posedge clk) disable iff (rst)
    (req_valid && win_en) |=> (!out_hit || out_write == $past(req_write)));
endmodule

// File: tb/tb_ecam_window_decoder.sv
`timescale 1ns/1ps
module tb_ecam_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wr_data = '0;
  logic        cfg_lock = 1'b0;
  logic [63:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [38:0] req_addr = '0;
  logic        out_valid, out_hit, out_write;
  logic [7:0]  out_bus;
  logic [4:0]  out_dev;
  logic [2:0]  out_fn;
  logic [11:0] out_off;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ecam_window_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_lock(cfg_lock), .cfg_rd_data(cfg_rd_data), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .out_valid(out_valid),
    .out_hit(out_hit), .out_write(out_write), .out_bus(out_bus),
    .out_dev(out_dev), .out_fn(out_fn), .out_off(out_off)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [63:0] m_reg;
  logic        e_valid, e_hit, e_write;
  logic [7:0]  e_bus;
  logic [4:0]  e_dev;
  logic [2:0]  e_fn;
  logic [11:0] e_off;
  int          m_lo, m_nb, m_len;
  bit          m_hit;

  always @(posedge clk) begin
    if (rst) begin
      m_reg = '0; e_valid = 0; e_hit = 0; e_write = 0;
      e_bus = 0; e_dev = 0; e_fn = 0; e_off = 0;
    end else begin
      m_len = int'(m_reg[2:1]);
      m_lo  = (m_len == 0) ? 28 : ((m_len == 1) ? 27 : 26);
      m_nb  = (m_len == 0) ? 8 : ((m_len == 1) ? 7 : 6);
      m_hit = req_valid && m_reg[0] && (m_len != 3) &&
              ((req_addr >> m_lo) == (m_reg[38:0] >> m_lo));
      e_valid = req_valid;
      e_hit   = m_hit;
      e_write = m_hit && req_write;
      if (m_hit) begin
        e_bus = 8'((req_addr >> 20) & ((39'd1 << m_nb) - 39'd1));
        e_dev = 5'((req_addr >> 15) & 39'h1f);
        e_fn  = 3'((req_addr >> 12) & 39'h7);
        e_off = 12'(req_addr & 39'hfff);
      end else begin
        e_bus = 0; e_dev = 0; e_fn = 0; e_off = 0;
      end
      if (cfg_wr_en && !cfg_lock) begin
        m_len = int'(cfg_wr_data[2:1]);
        m_reg = '0;
        m_reg[0] = cfg_wr_data[0];
        m_reg[2:1] = cfg_wr_data[2:1];
        m_reg[38:28] = cfg_wr_data[38:28];
        if (m_len == 1 || m_len == 2) m_reg[27] = cfg_wr_data[27];
        if (m_len == 2) m_reg[26] = cfg_wr_data[26];
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      check(cfg_rd_data == m_reg, "R8 register view", cfg_rd_data, m_reg);
      check(out_valid == e_valid, "R9 valid", 64'(out_valid), 64'(e_valid));
      check(out_hit == e_hit, "R2 hit", 64'(out_hit), 64'(e_hit));
      check(out_write == e_write, "R10 write", 64'(out_write), 64'(e_write));
      check({out_bus, out_dev, out_fn, out_off} == {e_bus, e_dev, e_fn, e_off},
            "R10 fields", 64'({out_bus, out_dev, out_fn, out_off}),
            64'({e_bus, e_dev, e_fn, e_off}));
    end
  end

  task automatic wr(input logic [63:0] d);
    cfg_wr_en = 1; cfg_wr_data = d;
    @(posedge clk); #1;
    cfg_wr_en = 0;
  endtask

  task automatic rd_expect(input logic [63:0] exp, input string tag);
    @(negedge clk);
    check(cfg_rd_data == exp, tag, cfg_rd_data, exp);
    @(posedge clk); #1;
  endtask

  task automatic rq(input logic [38:0] a, input bit w, input bit exp_hit,
                    input string tag);
    req_valid = 1; req_addr = a; req_write = w;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    check(out_hit == exp_hit, tag, 64'(out_hit), 64'(exp_hit));
    @(posedge clk); #1;
  endtask

  localparam logic [63:0] B   = 64'h0000_003A_5000_0000;
  localparam logic [63:0] B27 = 64'h1 << 27;
  localparam logic [63:0] B26 = 64'h1 << 26;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(cfg_rd_data == 64'h0, "R1 register", cfg_rd_data, 64'h0);
    check(out_valid == 0 && out_hit == 0, "R1 outputs", 64'({out_valid, out_hit}), 64'h0);
    rst = 0;
    @(posedge clk); #1;

    // 256 MB, enabled, with junk in mask and reserved bits (R3, R4, R5)
    wr(64'hFFFF_FF80_0000_0000 | B | B27 | B26 | 64'h3FF_FFF8 | 64'h1);
    rd_expect(B | 64'h1, "R5 reserved bits read zero");
    check(cfg_rd_data[27] == 0, "R3 bit27 masked at 256MB", 64'(cfg_rd_data[27]), 64'h0);
    check(cfg_rd_data[26] == 0, "R4 bit26 masked at 256MB", 64'(cfg_rd_data[26]), 64'h0);
    rq(39'(B + 64'h0ABC_D123), 1'b1, 1'b1, "R2 hit in 256MB window");
    rq(39'(B + 64'h0ABC_D123), 1'b1, 1'b1, "R10 repeat");
    req_valid = 1; req_addr = 39'(B + 64'h0ABC_D123); req_write = 1;
    @(posedge clk); #1; req_valid = 0;
    @(negedge clk);
    check(out_bus == 8'hAB, "R10 bus 256MB", 64'(out_bus), 64'hAB);
    check(out_off == 12'h123 && out_fn == 3'd5 && out_dev == 5'h19 && out_write,
          "R10 dev/fn/off", 64'({out_dev, out_fn, out_off}), 64'({5'h19, 3'd5, 12'h123}));
    @(posedge clk); #1;
    rq(39'(B + 64'h1000_0000), 1'b0, 1'b0, "R2 miss above 256MB window");

    // 128 MB
    wr(B | B27 | B26 | 64'h2 | 64'h1);
    rd_expect(B | B27 | 64'h3, "R3 bit27 kept at 128MB, R4 bit26 dropped");
    rq(39'(B), 1'b0, 1'b0, "R2 bit27 compared at 128MB");
    req_valid = 1; req_addr = 39'(B | B27 | 64'h07F0_0000); req_write = 0;
    @(posedge clk); #1; req_valid = 0;
    @(negedge clk);
    check(out_hit && out_bus == 8'h7F && !out_write, "R10 bus limited at 128MB",
          64'(out_bus), 64'h7F);
    @(posedge clk); #1;

    // 64 MB
    wr(B | B27 | B26 | 64'h4 | 64'h1);
    rd_expect(B | B27 | B26 | 64'h5, "R4 bit26 kept at 64MB");
    req_valid = 1; req_addr = 39'(B | B27 | B26 | 64'h03F0_0000); req_write = 0;
    @(posedge clk); #1; req_valid = 0;
    @(negedge clk);
    check(out_hit && out_bus == 8'h3F, "R10 bus limited at 64MB", 64'(out_bus), 64'h3F);
    @(posedge clk); #1;
    rq(39'(B | B27), 1'b0, 1'b0, "R2 bit26 compared at 64MB");

    // disabled
    wr(B | B26 | 64'h4);
    rd_expect(B | B26 | 64'h4, "R6 base writable while disabled");
    rq(39'(B | B26), 1'b1, 1'b0, "R6 no claim while disabled");

    // reserved size
    wr(B | B27 | B26 | 64'h7);
    rd_expect(B | 64'h7, "R7 mask bits zero at reserved size");
    rq(39'(B), 1'b0, 1'b0, "R7 no claim at reserved size");

    // lock
    wr(B | 64'h1);
    cfg_lock = 1;
    wr(64'h0000_0012_3C00_0005);
    rd_expect(B | 64'h1, "R8 write ignored while locked");
    rq(39'(B + 64'h5), 1'b0, 1'b1, "R8 decode unchanged while locked");
    cfg_lock = 0;
    @(posedge clk); #1;

    // random phase, checked every cycle against the model
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] d;
      logic [38:0] a;
      cfg_lock  = ($urandom_range(0, 9) == 0);
      cfg_wr_en = ($urandom_range(0, 9) == 0);
      d = {$urandom(), $urandom()};
      d[38:28] = (($urandom_range(0, 3) == 0) ? d[38:28] : B[38:28]);
      d[0] = ($urandom_range(0, 4) != 0);
      cfg_wr_data = d;
      a = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) != 0) a[38:29] = cfg_rd_data[38:29];
      req_valid = ($urandom_range(0, 9) < 7);
      req_write = $urandom_range(0, 1);
      req_addr  = a;
      @(posedge clk); #1;
    end
    cfg_wr_en = 0; req_valid = 0; cfg_lock = 0;
    @(posedge clk); #1;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule